// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address of every data phase of a burst on a parallel multiplexed bus. It can sit on the target side or on the initiator side. A burst starts when a start byte address is loaded together with a cache-line size selector, a 32/64-bit path flag and an optional phase limit. The two lowest bits of the start address choose the ordering of the burst:

- linear, which counts upward;
- cache-line wrap, which counts upward and folds back to the start of the line;
- toggle, which XORs the start word with a phase offset.

The address moves on only when a data phase completes, which is a cycle where both the initiator-ready and the target-ready strobes are high. On a 64-bit path each phase consumes two 32-bit words.

Besides the address, the block reports two things. A line-end flag tells a coherency-aware target that the current phase is the last one before a cache-line boundary would be crossed, so it can terminate the burst. A stop flag marks the final phase forced by the block itself, either by the phase limit or by the reserved ordering code. Either side can also request termination at any time. The sequence then freezes once the present phase completes.

The controller is a four-state machine:

- `ST_IDLE` is the state after reset.
- `ST_RUN` is a burst in progress.
- `ST_LAST` means termination has been requested and the current phase is the last one.
- `ST_DONE` means the burst is finished and the last address is held.

Its transitions are:

- load, from any state to `ST_RUN`;
- advance, from `ST_RUN` back to `ST_RUN` on a completed phase;
- arm, from `ST_RUN` to `ST_LAST` on a terminate request without a completed phase;
- finish, from `ST_RUN` to `ST_DONE` on a completed phase together with a stop or a terminate request;
- close, from `ST_LAST` to `ST_DONE` on a completed phase.

Top module: `burst_seq_gen`

## Requirements
- R1: After reset the block is idle: `addr_o` is 0, and `active_o`, `done_o`, `stop_o` and `line_end_o` are 0.
- R2: A cycle with `load_i` high starts a burst. On the next cycle `active_o` is 1 and `addr_o` equals `start_addr_i` with bits [1:0] cleared. Bits [1:0] of the start address select the ordering: 00 linear, 10 cache-line wrap, 01 toggle, 11 reserved.
- R3: While a burst is active, `addr_o` changes only after a cycle in which both `init_rdy_i` and `tgt_rdy_i` are 1 (a completed phase). A single strobe on its own leaves it unchanged.
- R4: In linear order, each completed phase adds 4 to `addr_o` on a 32-bit path. Cache-line boundaries are crossed freely.
- R5: In wrap order the line holds L = 4 << `line_sel_i` words. The word index within the line increases per phase modulo L, and the address bits above the line stay constant.
- R6: In toggle order, the low log2(L) bits of the word address equal the start word's low bits XOR the word offset. The word offset is the phase count, or twice the phase count on a 64-bit path. The upper bits stay constant.
- R7: With `wide_i` = 1 the word offset grows by 2 per phase (8 bytes) in every ordering.
- R8: `line_end_o` is 1 while active when the current phase is the last before a line boundary. In linear order this means the phase covers the line's last word. In wrap or toggle order it means that, with this phase, all L words of the line are delivered.
- R9: A terminate request ends the burst after the phase that completes in the same cycle or, failing that, after the next completed phase. `addr_o` then keeps that phase's address.
- R10: With a nonzero `max_phases_i` = M, `stop_o` is 1 during phase number M, and the burst ends when that phase completes. With M = 0 there is no limit.
- R11: The reserved ordering code 11 raises `stop_o` in the first phase, and the burst ends after that phase.
- R12: A load while a burst is running or done restarts the sequence at the new start address with the phase count at zero.
- R13: When done, `active_o` is 0, `done_o` is 1, and `addr_o` holds the last address regardless of further strobes, until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load a new burst |
| start_addr_i | input | AW | Start byte address; bits [1:0] carry the ordering code |
| line_sel_i | input | 2 | Cache-line size: 4 << value words |
| wide_i | input | 1 | 1 = 64-bit data path |
| max_phases_i | input | PW | Phase limit, 0 = unlimited |
| init_rdy_i | input | 1 | Initiator-ready strobe |
| tgt_rdy_i | input | 1 | Target-ready strobe |
| term_req_i | input | 1 | Request to end after the current phase |
| addr_o | output | AW | Current data-phase byte address |
| active_o | output | 1 | Burst in progress |
| stop_o | output | 1 | Current phase is the final one (limit or reserved code) |
| line_end_o | output | 1 | Current phase is the last before a line boundary |
| done_o | output | 1 | Burst finished, address frozen |

## Verification
The bench builds the block with its default parameters: a 32-bit address and an 8-bit phase counter. All four cache-line sizes are selected at run time, so wrap and toggle folding is exercised at 4-, 8-, 16- and 32-word lines, including starts near the top of a line. The 8-bit limit lets short phase limits be checked against the unlimited setting. The 32-bit address leaves room for linear bursts that run past line boundaries without the upper bits being disturbed.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        ORD_LINEAR = 2'b00,
        ORD_TOGGLE = 2'b01,
        ORD_WRAP   = 2'b10,
        ORD_RSVD   = 2'b11
    } order_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_LAST,
        ST_DONE
    } seq_state_e;

    localparam int MIN_LINE_LOG2 = 2;

endpackage

// File: rtl/burst_line_mask.sv
module burst_line_mask #(
    parameter int WAW   = 30,
    parameter int SEL_W = 2
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [WAW-1:0]   lmask_o
);
    import burst_seq_pkg::*;

    logic [7:0] line_log2;
    assign line_log2 = 8'(MIN_LINE_LOG2) + 8'(sel_i);

    for (genvar g = 0; g < WAW; g++) begin : g_mask
        assign lmask_o[g] = (g < int'(line_log2));
    end
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc #(
    parameter int WAW = 30,
    parameter int PW  = 8
) (
    input  burst_seq_pkg::order_e ord_i,
    input  logic [WAW-1:0]        base_w_i,
    input  logic [WAW-1:0]        lmask_i,
    input  logic [PW-1:0]         cnt_i,
    input  logic                  wide_i,
    output logic [WAW-1:0]        off_o,
    output logic [WAW-1:0]        cur_w_o
);
    import burst_seq_pkg::*;

    logic [WAW-1:0] line_base;

    always_comb begin
        off_o = WAW'(cnt_i);
        if (wide_i) begin
            off_o = off_o << 1;
        end
        line_base = base_w_i & ~lmask_i;
        unique case (ord_i)
            ORD_WRAP:   cur_w_o = line_base | ((base_w_i + off_o) & lmask_i);
            ORD_TOGGLE: cur_w_o = line_base | ((base_w_i ^ off_o) & lmask_i);
            default:    cur_w_o = base_w_i + off_o;
        endcase
    end
endmodule

// File: rtl/burst_stop_eval.sv
module burst_stop_eval #(
    parameter int WAW = 30,
    parameter int PW  = 8
) (
    input  burst_seq_pkg::order_e ord_i,
    input  logic [WAW-1:0]        cur_w_i,
    input  logic [WAW-1:0]        off_i,
    input  logic [WAW-1:0]        lmask_i,
    input  logic                  wide_i,
    input  logic [PW-1:0]         cnt_i,
    input  logic [PW-1:0]         max_i,
    output logic                  line_end_o,
    output logic                  limit_o
);
    import burst_seq_pkg::*;

    logic [WAW:0]   span;
    logic [WAW-1:0] last_w;
    logic           lin_end;
    logic           full_line;
    logic           max_hit;

    always_comb begin
        span      = {1'b0, off_i} + (wide_i ? (WAW+1)'(2) : (WAW+1)'(1));
        full_line = span > {1'b0, lmask_i};
        last_w    = cur_w_i + WAW'(wide_i);
        lin_end   = (last_w & lmask_i) == lmask_i;
        max_hit   = (max_i != '0) && (({1'b0, cnt_i} + (PW+1)'(1)) == {1'b0, max_i});
        unique case (ord_i)
            ORD_WRAP, ORD_TOGGLE: line_end_o = full_line;
            default:              line_end_o = lin_end;
        endcase
        limit_o = max_hit || (ord_i == ORD_RSVD);
    end
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen #(
    parameter int AW    = 32,
    parameter int PW    = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [AW-1:0]    start_addr_i,
    input  logic [SEL_W-1:0] line_sel_i,
    input  logic             wide_i,
    input  logic [PW-1:0]    max_phases_i,
    input  logic             init_rdy_i,
    input  logic             tgt_rdy_i,
    input  logic             term_req_i,
    output logic [AW-1:0]    addr_o,
    output logic             active_o,
    output logic             stop_o,
    output logic             line_end_o,
    output logic             done_o
);
    import burst_seq_pkg::*;

    localparam int WAW = AW - 2;

    seq_state_e       state_q, state_d;
    order_e           ord_q;
    logic [WAW-1:0]   base_w_q;
    logic [SEL_W-1:0] sel_q;
    logic             wide_q;
    logic [PW-1:0]    max_q;
    logic [PW-1:0]    cnt_q;
    logic             cnt_inc;

    logic [WAW-1:0]   lmask;
    logic [WAW-1:0]   off;
    logic [WAW-1:0]   cur_w;
    logic             line_end_raw;
    logic             limit_raw;
    logic             phase_done;

    assign phase_done = init_rdy_i && tgt_rdy_i;

    burst_line_mask #(.WAW(WAW), .SEL_W(SEL_W)) mask_i (
        .sel_i   (sel_q),
        .lmask_o (lmask)
    );

    burst_addr_calc #(.WAW(WAW), .PW(PW)) calc_i (
        .ord_i    (ord_q),
        .base_w_i (base_w_q),
        .lmask_i  (lmask),
        .cnt_i    (cnt_q),
        .wide_i   (wide_q),
        .off_o    (off),
        .cur_w_o  (cur_w)
    );

    burst_stop_eval #(.WAW(WAW), .PW(PW)) stop_i (
        .ord_i      (ord_q),
        .cur_w_i    (cur_w),
        .off_i      (off),
        .lmask_i    (lmask),
        .wide_i     (wide_q),
        .cnt_i      (cnt_q),
        .max_i      (max_q),
        .line_end_o (line_end_raw),
        .limit_o    (limit_raw)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_inc = 1'b0;
        if (load_i) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RUN: begin
                    if (phase_done && (limit_raw || term_req_i)) begin
                        state_d = ST_DONE;
                    end else if (phase_done) begin
                        cnt_inc = 1'b1;
                    end else if (term_req_i) begin
                        state_d = ST_LAST;
                    end
                end
                ST_LAST: begin
                    if (phase_done) begin
                        state_d = ST_DONE;
                    end
                end
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state and burst context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ord_q    <= ORD_LINEAR;
            base_w_q <= '0;
            sel_q    <= '0;
            wide_q   <= 1'b0;
            max_q    <= '0;
            cnt_q    <= '0;
        end else begin
            state_q <= state_d;
            if (load_i) begin
                ord_q    <= order_e'(start_addr_i[1:0]);
                base_w_q <= start_addr_i[AW-1:2];
                sel_q    <= line_sel_i;
                wide_q   <= wide_i;
                max_q    <= max_phases_i;
                cnt_q    <= '0;
            end else if (cnt_inc) begin
                cnt_q <= cnt_q + PW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        active_o   = 1'b0;
        done_o     = 1'b0;
        stop_o     = 1'b0;
        line_end_o = 1'b0;
        addr_o     = {cur_w, 2'b00};
        unique case (state_q)
            ST_IDLE: addr_o = '0;
            ST_RUN, ST_LAST: begin
                active_o   = 1'b1;
                stop_o     = limit_raw;
                line_end_o = line_end_raw;
            end
            ST_DONE: done_o = 1'b1;
            default: addr_o = '0;
        endcase
    end

    // ---------------- assertions ----------------
    logic [AW-1:0] line_bytes;
    assign line_bytes = {lmask, 2'b11};

    assert_hold_without_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !phase_done && !load_i) |=> $stable(addr_o));

    assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && phase_done && !stop_o && !term_req_i && !load_i
         && ord_q == ORD_LINEAR)
        |=> addr_o == $past(addr_o) + (wide_q ? AW'(8) : AW'(4)));   // R7 step size

    assert_wrap_in_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && phase_done && !stop_o && !term_req_i && !load_i
         && ord_q == ORD_WRAP)
        |=> (addr_o & ~line_bytes) == $past(addr_o & ~line_bytes));

    assert_limit_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && phase_done && stop_o && !load_i) |=> done_o);

    assert_reserved_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && ord_q == ORD_RSVD) |-> stop_o);

    assert_done_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !load_i) |=> (done_o && !active_o && $stable(addr_o)));

    assert_load_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (active_o && addr_o == {$past(start_addr_i[AW-1:2]), 2'b00}));

endmodule

// File: tb/burst_seq_gen_tb_top.sv
`timescale 1ns/1ps
module burst_seq_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic [1:0]  line_sel_i = '0;
    logic        wide_i = 1'b0;
    logic [7:0]  max_phases_i = '0;
    logic        init_rdy_i = 1'b0;
    logic        tgt_rdy_i = 1'b0;
    logic        term_req_i = 1'b0;
    logic [31:0] addr_o;
    logic        active_o, stop_o, line_end_o, done_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    burst_seq_gen dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_addr_i(start_addr_i),
        .line_sel_i(line_sel_i), .wide_i(wide_i), .max_phases_i(max_phases_i),
        .init_rdy_i(init_rdy_i), .tgt_rdy_i(tgt_rdy_i), .term_req_i(term_req_i),
        .addr_o(addr_o), .active_o(active_o), .stop_o(stop_o),
        .line_end_o(line_end_o), .done_o(done_o)
    );

    // {start[31:0], line_sel[1:0], wide, phases[3:0], expected addr[31:0]}
    localparam logic [70:0] VEC [8] = '{
        {32'h0000_0100, 2'd0, 1'b0, 4'd5, 32'h0000_0114},  // linear R4
        {32'h0000_010E, 2'd0, 1'b0, 4'd2, 32'h0000_0104},  // wrap R5
        {32'h0000_020A, 2'd1, 1'b1, 4'd4, 32'h0000_0208},  // wrap wide R7
        {32'h0000_030D, 2'd0, 1'b0, 4'd2, 32'h0000_0304},  // toggle R6
        {32'h0000_0415, 2'd1, 1'b1, 4'd3, 32'h0000_040C},  // toggle wide R7
        {32'h0000_1000, 2'd0, 1'b1, 4'd3, 32'h0000_1018},  // linear wide R7
        {32'h0000_05FA, 2'd3, 1'b0, 4'd3, 32'h0000_0584},  // wrap 32-word R5
        {32'h0000_06C5, 2'd2, 1'b0, 4'd7, 32'h0000_06D8}   // toggle 16-word R6
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(input logic [31:0] a, input logic [1:0] sel, input logic w,
                        input logic [7:0] mx);
        @(negedge clk);
        load_i = 1'b1; start_addr_i = a; line_sel_i = sel; wide_i = w; max_phases_i = mx;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic phase(input logic ir, input logic tr, input logic term);
        @(negedge clk);
        init_rdy_i = ir; tgt_rdy_i = tr; term_req_i = term;
        @(negedge clk);
        init_rdy_i = 1'b0; tgt_rdy_i = 1'b0; term_req_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 addr", addr_o, 32'h0);
        check("R1 flags", {27'b0, active_o, done_o, stop_o, line_end_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", {31'b0, active_o}, 32'h0);

        // vector table: R4 R5 R6 R7
        foreach (VEC[i]) begin
            load(VEC[i][70:39], VEC[i][38:37], VEC[i][36], 8'd0);
            for (int p = 0; p < int'(VEC[i][35:32]); p++) phase(1'b1, 1'b1, 1'b0);
            check($sformatf("R4/R5/R6/R7 vector %0d addr", i), addr_o, VEC[i][31:0]);
            check($sformatf("R10 unlimited vector %0d", i), {30'b0, active_o, stop_o}, 32'h2);
        end

        // R2 load and ordering code stripped
        load(32'h0000_010E, 2'd0, 1'b0, 8'd0);
        check("R2 first addr", addr_o, 32'h0000_010C);
        check("R2 active", {31'b0, active_o}, 32'h1);

        // R3 single strobes are ignored
        load(32'h0000_0100, 2'd0, 1'b0, 8'd0);
        phase(1'b1, 1'b0, 1'b0);
        check("R3 init only", addr_o, 32'h0000_0100);
        phase(1'b0, 1'b1, 1'b0);
        check("R3 tgt only", addr_o, 32'h0000_0100);
        phase(1'b1, 1'b1, 1'b0);
        check("R3 both", addr_o, 32'h0000_0104);

        // R8 linear line end
        load(32'h0000_0108, 2'd0, 1'b0, 8'd0);
        check("R8 linear word2", {31'b0, line_end_o}, 32'h0);
        phase(1'b1, 1'b1, 1'b0);
        check("R8 linear word3", {31'b0, line_end_o}, 32'h1);
        phase(1'b1, 1'b1, 1'b0);
        check("R8 linear next line addr", addr_o, 32'h0000_0110);
        check("R8 linear next line", {31'b0, line_end_o}, 32'h0);
        load(32'h0000_0108, 2'd0, 1'b1, 8'd0);
        check("R8 wide covers last word", {31'b0, line_end_o}, 32'h1);
        // R8 wrap: line exhausted after 4 phases of a 4-word line
        load(32'h0000_010E, 2'd0, 1'b0, 8'd0);
        check("R8 wrap first", {31'b0, line_end_o}, 32'h0);
        for (int p = 0; p < 3; p++) phase(1'b1, 1'b1, 1'b0);
        check("R8 wrap fourth addr", addr_o, 32'h0000_0108);
        check("R8 wrap fourth", {31'b0, line_end_o}, 32'h1);

        // R9 terminate without phase, then phase
        load(32'h0000_0200, 2'd0, 1'b0, 8'd0);
        phase(1'b1, 1'b1, 1'b0);
        phase(1'b1, 1'b1, 1'b0);
        phase(1'b0, 1'b0, 1'b1);
        check("R9 still active after request", {31'b0, active_o}, 32'h1);
        check("R9 addr held pending", addr_o, 32'h0000_0208);
        phase(1'b1, 1'b1, 1'b0);
        check("R9 done after phase", {31'b0, done_o}, 32'h1);
        check("R9 frozen addr", addr_o, 32'h0000_0208);
        // R13 strobes after done
        phase(1'b1, 1'b1, 1'b0);
        check("R13 addr held", addr_o, 32'h0000_0208);
        check("R13 flags", {30'b0, active_o, done_o}, 32'h1);
        // R9 terminate with phase in same cycle
        load(32'h0000_0300, 2'd0, 1'b0, 8'd0);
        phase(1'b1, 1'b1, 1'b1);
        check("R9 same-cycle done", {31'b0, done_o}, 32'h1);
        check("R9 same-cycle addr", addr_o, 32'h0000_0300);

        // R10 phase limit of 3
        load(32'h0000_0400, 2'd0, 1'b0, 8'd3);
        check("R10 phase1 no stop", {31'b0, stop_o}, 32'h0);
        phase(1'b1, 1'b1, 1'b0);
        check("R10 phase2 no stop", {31'b0, stop_o}, 32'h0);
        phase(1'b1, 1'b1, 1'b0);
        check("R10 phase3 stop", {31'b0, stop_o}, 32'h1);
        phase(1'b1, 1'b1, 1'b0);
        check("R10 done", {31'b0, done_o}, 32'h1);
        check("R10 final addr", addr_o, 32'h0000_0408);

        // R11 reserved ordering code
        load(32'h0000_0503, 2'd0, 1'b0, 8'd0);
        check("R11 addr", addr_o, 32'h0000_0500);
        check("R11 stop", {31'b0, stop_o}, 32'h1);
        phase(1'b1, 1'b1, 1'b0);
        check("R11 done", {31'b0, done_o}, 32'h1);

        // R12 restart from done and mid-burst
        load(32'h0000_0700, 2'd0, 1'b0, 8'd0);
        check("R12 restart from done", addr_o, 32'h0000_0700);
        phase(1'b1, 1'b1, 1'b0);
        phase(1'b1, 1'b1, 1'b0);
        load(32'h0000_0800, 2'd0, 1'b0, 8'd0);
        check("R12 mid-burst reload", addr_o, 32'h0000_0800);
        phase(1'b1, 1'b1, 1'b0);
        check("R12 counter restarted", addr_o, 32'h0000_0804);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule